// File: doc/BRIEF.md
# Protected Test-Interrupt and Reset Mask Register

This block is a single configuration register on a simple register bus. Software uses it for two debug and production-test jobs. The first job is to raise a test event on any one of 64 interrupt lines. That event is guarded by a two-bit key field: an event is produced only when the new key value is the bitwise inverse of the key value already held. A stray write therefore rarely triggers an interrupt by accident. The second job is to mask three raw reset requests before they reach the reset sequencer. The three requests are the watchdog, processor-error and bus-controller requests.

Every write replaces the whole register. The read port always shows the stored value. The masked reset outputs are combinational, so a mask bit takes effect as soon as it is stored. A test event appears as a one-cycle pulse in the cycle after the write edge.

Top module: `irq_test_rst_mask`

## Requirements
- R1: After reset, rd_data is zero, irq_evt is zero, and every raw reset request passes to its output unchanged.
- R2: A write stores wr_data[10:0]. rd_data[10:0] returns the stored bits. rd_data bits 31:11 always read zero, and the written values of those bits are ignored.
- R3: A write whose key bits wr_data[10:9] equal the bitwise inverse of the stored key raises exactly one line of irq_evt: the line numbered wr_data[8:3]. The line rises in the cycle after the write edge and stays high for that one cycle only.
- R4: A write whose key is not the inverse of the stored key still updates every field, including the key, and raises no line of irq_evt.
- R5: A cycle without wr_en leaves the register unchanged, and irq_evt is zero in the following cycle.
- R6: While stored bit 1 is set, wdog_rst_out is low. While it is clear, wdog_rst_out follows wdog_req.
- R7: While stored bit 0 is set, cpu_err_rst_out is low. While it is clear, cpu_err_rst_out follows cpu_err_req.
- R8: While stored bit 2 is set, bc_rst_out is low. While it is clear, bc_rst_out follows bc_rst_req.
- R9: The line raised by an event is chosen by the source field of the triggering write itself, not by the source value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| wdog_req | input | 1 | Raw watchdog reset request |
| cpu_err_req | input | 1 | Raw processor-error reset request |
| bc_rst_req | input | 1 | Raw bus-controller core reset request |
| wdog_rst_out | output | 1 | Watchdog request after masking |
| cpu_err_rst_out | output | 1 | Processor-error request after masking |
| bc_rst_out | output | 1 | Bus-controller reset after masking |
| irq_evt | output | 64 | One-cycle test interrupt event, one line per source |

## Verification
A wrong stored key shows up at the first key write that follows. Such a write fires when it should stay silent, or stays silent when it should fire, and the bench sees this on irq_evt one cycle after the edge. A corrupted mask bit or source field shows up at once: rd_data differs from the written value, a gated reset output misbehaves in the same cycle the request is driven, or the wrong line pulses. Random writes, idle cycles and reset requests are mixed so that each stored bit is observed both directly and through its effect.

// File: rtl/irq_test_rst_mask.sv
module irq_test_rst_mask #(
  parameter int DATA_W = 32,
  parameter int IRQ_N  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wdog_req,
  input  logic              cpu_err_req,
  input  logic              bc_rst_req,
  output logic              wdog_rst_out,
  output logic              cpu_err_rst_out,
  output logic              bc_rst_out,
  output logic [IRQ_N-1:0]  irq_evt
);
  localparam int SRC_W = $clog2(IRQ_N);
  localparam int SRC_LO = 3;
  localparam int KEY_LO = SRC_LO + SRC_W;
  localparam int FLD_W = KEY_LO + 2;

  logic [FLD_W-1:0] cfg_q;
  logic [1:0]       key_q, key_d;
  logic [SRC_W-1:0] src_d;
  logic             fire;
  logic             unused_hi;

  assign key_q = cfg_q[KEY_LO +: 2];
  assign key_d = wr_data[KEY_LO +: 2];
  assign src_d = wr_data[SRC_LO +: SRC_W];
  assign fire  = wr_en && (key_d == ~key_q);
  assign unused_hi = ^wr_data[DATA_W-1:FLD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      irq_evt <= '0;
    end else begin
      if (wr_en) cfg_q <= wr_data[FLD_W-1:0];
      irq_evt <= fire ? ({{(IRQ_N-1){1'b0}}, 1'b1} << src_d) : '0;
    end
  end

  assign rd_data         = {{(DATA_W-FLD_W){1'b0}}, cfg_q};
  assign cpu_err_rst_out = cpu_err_req & ~cfg_q[0];
  assign wdog_rst_out    = wdog_req    & ~cfg_q[1];
  assign bc_rst_out      = bc_rst_req  & ~cfg_q[2];

  // R3
  evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_evt));
  // R5
  idle_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> irq_evt == '0);
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
  // R6
  wdog_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_out |-> !rd_data[1] && wdog_req);
  // R7
  cpu_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err_rst_out |-> !rd_data[0] && cpu_err_req);
  // R8
  bc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc_rst_out |-> !rd_data[2] && bc_rst_req);
  // R2
  hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:FLD_W] == '0);
endmodule

// File: tb/sim_irq_test_rst_mask.sv
module sim_irq_test_rst_mask;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic wdog_req = 0, cpu_err_req = 0, bc_rst_req = 0;
  logic wdog_rst_out, cpu_err_rst_out, bc_rst_out;
  logic [63:0] irq_evt;
  int checks = 0, errors = 0;
  logic [10:0] m = 0;
  logic [63:0] exp_evt;

  always #10 clk = ~clk;

  irq_test_rst_mask u0 (.clk, .rst_n, .wr_en, .wr_data, .rd_data, .wdog_req,
    .cpu_err_req, .bc_rst_req, .wdog_rst_out, .cpu_err_rst_out, .bc_rst_out, .irq_evt);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] evt_of(logic [10:0] cur, logic [31:0] d, logic we);
    if (we && d[10:9] == ~cur[10:9]) return 64'd1 << d[8:3];
    return 64'd0;
  endfunction

  task automatic step(logic we, logic [31:0] d, logic [2:0] rq);
    @(negedge clk);
    wr_en = we; wr_data = d;
    {bc_rst_req, wdog_req, cpu_err_req} = rq;
    #2;
    chk("R7", cpu_err_rst_out, rq[0] & ~m[0]);
    chk("R6", wdog_rst_out, rq[1] & ~m[1]);
    chk("R8", bc_rst_out, rq[2] & ~m[2]);
    exp_evt = evt_of(m, d, we);
    if (we) m = d[10:0];
    @(posedge clk); #5;
    if (!we) chk("R5", irq_evt, 64'd0);
    else if (exp_evt != 0) chk("R3 R9", irq_evt, exp_evt);
    else chk("R4", irq_evt, 64'd0);
    chk("R2", rd_data, {21'd0, m});
  endtask

  initial begin
    #200000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cpu_err_req = 1; wdog_req = 1; bc_rst_req = 1;
    #1;
    chk("R1", rd_data, 0);
    chk("R1", irq_evt, 0);
    chk("R1", {bc_rst_out, wdog_rst_out, cpu_err_rst_out}, 3'b111);
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R3 first key write 11 against reset key 00, source 63
    step(1, {21'h1FFFFF, 2'b11, 6'd63, 3'b000}, 3'b111);
    // R3 pulse lasts one cycle
    step(0, 0, 3'b111);
    // R4 same key again: no event, stored
    step(1, {2'b11, 6'd5, 3'b111} , 3'b111);
    // R9 inverse key with new source 0 while stored source is 5
    step(1, {2'b00, 6'd0, 3'b010}, 3'b111);
    // R4 key 01 vs 00: not inverse
    step(1, {2'b01, 6'd7, 3'b101}, 3'b111);
    step(1, {2'b10, 6'd33, 3'b000}, 3'b000);
    step(0, 0, 3'b101);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom % 3 == 0) d[10:9] = ~m[10:9];
      step(($urandom % 4) != 0, d, 3'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule